// File: doc/BRIEF.md
# Pin I/O Controller with Change Interrupts

This block is a register-mapped controller for up to 32 general-purpose pins. Software decides for each pin whether it drives an output level or is observed as an input. The controller synchronises every input, notices any level change on it in either direction, and records that change in a sticky pending register. Any pending pin that is also unmasked raises one shared interrupt line toward a parent interrupt controller.

The register port is a single-cycle interface: a byte address, a write strobe with 32-bit write data, and combinational 32-bit read data. Software acknowledges a pin's change by writing a one to its pending bit. A per-register write mask protects output bits that are not being updated in a data write, so software does not need a read-modify-write sequence.

Top module: `gpio_change_ctrl`

## Requirements
- R1: Registers sit at byte offsets 0x00 direction, 0x04 data, 0x08 interrupt enable, 0x0C change status, 0x10 write mask and 0x14 trigger type. Only addresses whose two low bits are 0 are decoded. Offsets 0x18 and 0x1C, and any misaligned address, read as zero and ignore writes.
- R2: A direction bit of 1 makes that pin an output, and `pin_oe` reflects that bit. All direction bits reset to 0, which means input.
- R3: Reading the data register returns one level per pin. For an output pin this is the driven value. For an input pin it is the input after a two-flop synchroniser, so a change on the pin appears two rising edges later.
- R4: A rising or a falling change on an input pin sets that pin's change bit at the third rising edge after the change. A pin whose direction bit is 1 sets no change bit.
- R5: Writing 1 to a change bit clears it, and writing 0 leaves it as it was. If a new change of a pin lands in the same cycle as the clear of that pin's bit, the bit stays set.
- R6: The interrupt-enable register resets to 0 and holds what is written to it. A 1 unmasks the pin.
- R7: `irq` is a registered output. It is high in the cycle after the bitwise AND of the change and enable registers is non-zero, and it is low in the cycle after that AND is zero.
- R8: A data write updates only the bits whose write-mask bit is 1. The write mask resets to all ones. `pin_out` presents the data register.
- R9: The trigger-type register resets to all ones, meaning both edges, and holds what is written to it. Its contents never change how changes are detected.
- R10: With NPINS pins, bits NPINS..31 of every register read as zero.
- R11: After reset, every register reads its reset value and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Byte address of the register access |
| wr_en | input | 1 | Write strobe, one access per cycle |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| pin_in | input | NPINS | Pin levels seen from the pads |
| pin_out | output | NPINS | Output levels driven to the pads |
| pin_oe | output | NPINS | Output enable per pin |
| irq | output | 1 | Combined change interrupt |

## Verification
A wrong synchroniser depth or a bad edge register shows up at the ports within three or four cycles. The change bit appears a cycle early or late, or it appears for an output pin, and `irq` rises at the wrong edge. A lost or stuck pending bit is visible at the next read of offset 0x0C, and also through `irq` once that bit is enabled. A mishandled mask or a mishandled clear-versus-change collision corrupts the read value immediately. The bench therefore compares every register read, `irq`, `pin_out` and `pin_oe` against a behavioural model on every cycle, with directed collisions and random traffic.

// File: rtl/gpio_change_ctrl.sv
module gpio_change_ctrl #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       addr,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  localparam logic [2:0] SEL_DIR = 3'd0;
  localparam logic [2:0] SEL_DAT = 3'd1;
  localparam logic [2:0] SEL_IEN = 3'd2;
  localparam logic [2:0] SEL_CHG = 3'd3;
  localparam logic [2:0] SEL_WM  = 3'd4;
  localparam logic [2:0] SEL_TYP = 3'd5;

  logic [NPINS-1:0] dir_q, dat_q, ien_q, chg_q, wm_q, typ_q;
  logic [NPINS-1:0] sync1_q, sync2_q, prev_q;
  logic             irq_q;
  logic [NPINS-1:0] view;

  wire              aligned = (addr[1:0] == 2'b00);
  wire [2:0]        sel     = addr[4:2];
  wire              wr_hit  = wr_en && aligned;
  wire [NPINS-1:0]  wbits   = wr_data[NPINS-1:0];
  wire [NPINS-1:0]  edges   = (sync2_q ^ prev_q) & ~dir_q;
  wire [NPINS-1:0]  level   = (dir_q & dat_q) | (~dir_q & sync2_q);
  wire [NPINS-1:0]  ack     = (wr_hit && sel == SEL_CHG) ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      dat_q <= '0;
      ien_q <= '0;
      wm_q  <= '1;
      typ_q <= '1;
    end else if (wr_hit) begin
      case (sel)
        SEL_DIR: dir_q <= wbits;
        SEL_DAT: dat_q <= (dat_q & ~wm_q) | (wbits & wm_q);
        SEL_IEN: ien_q <= wbits;
        SEL_WM:  wm_q  <= wbits;
        SEL_TYP: typ_q <= wbits;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_q <= '0;
      irq_q <= 1'b0;
    end else begin
      chg_q <= (chg_q & ~ack) | edges;
      irq_q <= |(chg_q & ien_q);
    end
  end

  always_comb begin
    view = '0;
    if (aligned) begin
      case (sel)
        SEL_DIR: view = dir_q;
        SEL_DAT: view = level;
        SEL_IEN: view = ien_q;
        SEL_CHG: view = chg_q;
        SEL_WM:  view = wm_q;
        SEL_TYP: view = typ_q;
        default: view = '0;
      endcase
    end
    rd_data = 32'(view);
  end

  assign pin_out = dat_q;
  assign pin_oe  = dir_q;
  assign irq     = irq_q;

  AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(chg_q & ien_q)) |=> irq);  // R7
  AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(chg_q & ien_q)) |=> !irq);  // R7
  AST_CHG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_hit && sel == SEL_CHG) |=> ((chg_q & $past(chg_q)) == $past(chg_q)));  // R5
  AST_DIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_hit && sel == SEL_DIR) |=> $stable(pin_oe));  // R2
  AST_OUT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pin_out ^ $past(pin_out)) & ~$past(wm_q)) == '0));  // R8
  AST_NO_OUTPUT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((chg_q & ~$past(chg_q) & $past(dir_q)) == '0));  // R4
endmodule

// File: tb/gpio_change_ctrl_tb.sv
`timescale 1ns/100ps
module gpio_change_ctrl_tb;
  localparam int N = 12;
  localparam logic [31:0] MSK = (32'd1 << N) - 32'd1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] addr = '0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out, pin_oe;
  logic irq;

  int nchk = 0;
  int nfail = 0;
  int since_rst = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_change_ctrl #(.NPINS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  // behavioural model
  logic [31:0] m_dir, m_dat, m_ien, m_chg, m_wm, m_typ;
  logic        m_irq;
  logic [31:0] hist[$];

  function automatic logic [31:0] m_read(logic [4:0] a);
    logic [31:0] lvl;
    lvl = (m_dir & m_dat) | (~m_dir & hist[1]);
    if (a[1:0] != 2'b00) return 32'd0;
    case (a[4:2])
      3'd0: return m_dir;
      3'd1: return lvl & MSK;
      3'd2: return m_ien;
      3'd3: return m_chg;
      3'd4: return m_wm;
      3'd5: return m_typ;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = 0; m_dat = 0; m_ien = 0; m_chg = 0; m_wm = MSK; m_typ = MSK; m_irq = 0;
      hist = '{32'd0, 32'd0, 32'd0};
      since_rst = 0;
    end else begin
      logic [31:0] ack, edg, wd;
      logic        irq_n;
      wd    = wr_data & MSK;
      ack   = 0;
      edg   = (hist[1] ^ hist[2]) & ~m_dir;
      irq_n = |(m_chg & m_ien);
      if (wr_en && addr[1:0] == 2'b00) begin
        case (addr[4:2])
          3'd0: m_dir = wd;
          3'd1: m_dat = (m_dat & ~m_wm) | (wd & m_wm);
          3'd2: m_ien = wd;
          3'd3: ack = wd;
          3'd4: m_wm = wd;
          3'd5: m_typ = wd;
          default: ;
        endcase
      end
      m_chg = (m_chg & ~ack) | edg;
      m_irq = irq_n;
      hist.push_front(32'(pin_in));
      void'(hist.pop_back());
      since_rst++;
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string tag_of(logic [4:0] a);
    if (since_rst < 8) return "R11";
    if (a[1:0] != 2'b00) return "R1";
    case (a[4:2])
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R6";
      3'd3: return "R4 R5";
      3'd4: return "R8";
      3'd5: return "R9";
      default: return "R1";
    endcase
  endfunction

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(tag_of(addr), rd_data, m_read(addr));
      chk("R10", {20'd0, rd_data[31:N]}, 32'd0);
      chk("R7", {31'd0, irq}, {31'd0, m_irq});
      chk("R8", 32'(pin_out), m_dat);
      chk("R2", 32'(pin_oe), m_dir);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
      addr = 5'(4 * (i % 8));
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_expect(string tag, logic [4:0] a, logic [31:0] e);
    @(negedge clk);
    wr_en = 1'b0; addr = a;
    #1;
    chk(tag, rd_data, e);
  endtask

  initial begin
    #(200000 * 5);
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(8);
    rd_expect("R11", 5'h10, MSK);
    rd_expect("R11", 5'h14, MSK);
    chk("R11", {31'd0, irq}, 32'd0);

    // R8 masked data write, R2 direction
    wr(5'h00, 32'h0000_00F0);
    wr(5'h10, 32'h0000_0030);
    wr(5'h04, 32'hFFFF_FFFF);
    rd_expect("R8", 5'h04, 32'h0000_0030);
    wr(5'h10, MSK);
    idle(4);

    // R4 rising edge on input pin 0, exact latency
    wr(5'h08, 32'h0000_0001);
    @(negedge clk); pin_in[0] = 1'b1; addr = 5'h0C;
    @(negedge clk); #1; chk("R4", rd_data, 32'd0);
    @(negedge clk); #1; chk("R4", rd_data, 32'd0);
    @(negedge clk); #1; chk("R4", rd_data, 32'd1);
    chk("R7", {31'd0, irq}, 32'd0);
    @(negedge clk); #1; chk("R7", {31'd0, irq}, 32'd1);

    // R5 collision: falling edge lands with the clear
    @(negedge clk); pin_in[0] = 1'b0;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 5'h0C; wr_data = 32'd1;
    @(negedge clk); wr_en = 1'b0;
    #1; chk("R5", rd_data, 32'd1);
    wr(5'h0C, 32'd0);
    rd_expect("R5", 5'h0C, 32'd1);
    wr(5'h0C, 32'd1);
    rd_expect("R5", 5'h0C, 32'd0);
    idle(2);
    chk("R7", {31'd0, irq}, 32'd0);

    // R4 output pin ignores input changes; R9 type write has no effect
    wr(5'h14, 32'd0);
    @(negedge clk); pin_in[5] = 1'b1;
    idle(5);
    rd_expect("R4", 5'h0C, 32'd0);
    @(negedge clk); pin_in[2] = 1'b1;
    idle(5);
    rd_expect("R9", 5'h0C, 32'h4);
    wr(5'h0C, MSK);
    rd_expect("R1", 5'h19, 32'd0);

    // random traffic against model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ($urandom_range(3) == 0) pin_in = N'($urandom);
      wr_en = ($urandom_range(4) == 0);
      addr = ($urandom_range(7) == 0) ? 5'($urandom) : 5'(4 * $urandom_range(7));
      wr_data = $urandom;
    end
    idle(6);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule